// File: doc/BRIEF.md
# Fixed-Point Saturating and Averaging Add/Subtract Lane

This block is one element lane of a vector fixed-point unit. It takes two SEW-bit operands and produces either a saturating or an averaging sum or difference, with signed or unsigned interpretation picked per operation. A single adder of SEW+1 bits serves every variant. In saturating mode the wide result is checked against the limits of the selected number format and clamped to the nearest limit when it falls outside. In averaging mode the wide result is halved and rounded under a 2-bit rounding-mode input.

The arithmetic is combinational. It is followed by one output register with a valid/ready handshake on both sides, so a stalled consumer holds the result and throttles the producer. A sticky saturation bit collects every clamp that occurred since it was last cleared.

Top module: `fxp_addavg`

## Requirements
- R1: With avg_mode=0, is_signed=0 and op_sub=0, a sum above 2^SEW-1 yields all ones with sat=1. A sum that fits yields the exact sum with sat=0.
- R2: With avg_mode=0, is_signed=0 and op_sub=1, a result where opb exceeds opa yields zero with sat=1. Otherwise the result is opa-opb with sat=0.
- R3: With avg_mode=0 and is_signed=1 (two's complement), a result above 2^(SEW-1)-1 yields that maximum and a result below -2^(SEW-1) yields that minimum, both with sat=1. This covers add and subtract.
- R4: In saturating mode, a result inside the representable range is passed unchanged with sat=0.
- R5: With avg_mode=1 and is_signed=0, the operands are zero-extended to SEW+1 bits and added or subtracted. The result is the low SEW bits of (W>>1)+inc, where W is the SEW+1-bit pattern and inc is the rounding increment of R7.
- R6: With avg_mode=1 and is_signed=1, the operands are sign-extended to SEW+1 bits and the same halving and rounding as in R5 applies. A rounded value beyond the SEW-bit range wraps to its low SEW bits.
- R7: The rounding increment is set by rnd_mode. In the formula, b0 is bit 0 of W and b1 is bit 1 of W. 0 rounds to nearest, ties up: inc=b0. 1 rounds to nearest, ties to even: inc=b0&b1. 2 truncates: inc=0. 3 jams to odd: inc=b0&~b1.
- R8: Averaging results always have sat=0.
- R9: An operation is accepted on a cycle with in_valid=1 and in_ready=1. Its result appears with out_valid=1 on the next cycle. While out_valid=1 and out_ready=0, in_ready is 0 and res and sat hold their values.
- R10: sat_sticky becomes 1 after an accepted operation that clamps. It stays 1 until a cycle with sticky_clr=1, which clears it. A clamp accepted in that same cycle wins over the clear.
- R11: After reset, out_valid=0, sat_sticky=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| op_sub | input | 1 | 1 = subtract opb from opa, 0 = add |
| is_signed | input | 1 | 1 = two's complement operands |
| avg_mode | input | 1 | 1 = averaging, 0 = saturating |
| rnd_mode | input | 2 | Rounding mode for averaging (R7) |
| opa | input | SEW | First operand |
| opb | input | SEW | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res | output | SEW | Result |
| sat | output | 1 | Result was clamped |
| sticky_clr | input | 1 | Clear the sticky saturation bit |
| sat_sticky | output | 1 | Accumulated saturation status |

## Verification
The assertions assume that opcode, mode and operand inputs carry known values whenever in_valid is high. They also assume that out_ready and sticky_clr are never unknown after reset, because the checker samples the inputs on the accepting edge and compares them with the registered result one cycle later. The stimulus drives all inputs only on the falling clock edge. It keeps in_valid and the operands steady until the offer is taken, and it randomises out_ready so that stalls and back-to-back transfers both occur.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_UP   = 2'd0,
        RND_NEAR_EVEN = 2'd1,
        RND_DOWN      = 2'd2,
        RND_ODD       = 2'd3
    } rnd_e;

endpackage

// File: rtl/fxp_wide_alu.sv
module fxp_wide_alu #(
    parameter int SEW = 8
) (
    input  logic [SEW-1:0] opa,
    input  logic [SEW-1:0] opb,
    input  logic           op_sub,
    input  logic           is_signed,
    output logic [SEW:0]   wide
);
    localparam int WIDE = SEW + 1;

    logic [WIDE-1:0] ext_a;
    logic [WIDE-1:0] ext_b;

    always_comb begin
        ext_a = {is_signed & opa[SEW-1], opa};
        ext_b = {is_signed & opb[SEW-1], opb};
        if (op_sub) begin
            wide = ext_a - ext_b;
        end else begin
            wide = ext_a + ext_b;
        end
    end

endmodule

// File: rtl/fxp_sat_clamp.sv
module fxp_sat_clamp #(
    parameter int SEW = 8
) (
    input  logic [SEW:0]   wide,
    input  logic           op_sub,
    input  logic           is_signed,
    output logic [SEW-1:0] clamped,
    output logic           clipped
);
    localparam logic [SEW-1:0] S_MAX = {1'b0, {(SEW-1){1'b1}}};
    localparam logic [SEW-1:0] S_MIN = {1'b1, {(SEW-1){1'b0}}};
    localparam logic [SEW-1:0] U_MAX = {SEW{1'b1}};
    localparam logic [SEW-1:0] U_MIN = {SEW{1'b0}};

    always_comb begin
        clamped = wide[SEW-1:0];
        clipped = 1'b0;
        if (is_signed) begin
            // out of range when the extra bit disagrees with the SEW-bit sign
            if (wide[SEW] != wide[SEW-1]) begin
                clipped = 1'b1;
                clamped = wide[SEW] ? S_MIN : S_MAX;
            end
        end else if (wide[SEW]) begin
            // carry out on add, borrow on subtract
            clipped = 1'b1;
            clamped = op_sub ? U_MIN : U_MAX;
        end
    end

endmodule

// File: rtl/fxp_half_round.sv
module fxp_half_round
    import fxp_pkg::*;
#(
    parameter int SEW = 8
) (
    input  logic [SEW:0]   wide,
    input  rnd_e           mode,
    output logic [SEW-1:0] halved
);
    localparam int WIDE = SEW + 1;

    logic cut_bit;
    logic keep_lsb;
    logic inc;

    always_comb begin
        cut_bit  = wide[0];
        keep_lsb = wide[1];
        unique case (mode)
            RND_NEAR_UP:   inc = cut_bit;
            RND_NEAR_EVEN: inc = cut_bit & keep_lsb;
            RND_DOWN:      inc = 1'b0;
            RND_ODD:       inc = cut_bit & ~keep_lsb;
            default:       inc = 1'b0;
        endcase
        // bits above the cut; arithmetic vs logical shift only differ in a dropped bit
        halved = wide[WIDE-1:1] + {{(SEW-1){1'b0}}, inc};
    end

endmodule

// File: rtl/fxp_addavg.sv
module fxp_addavg
    import fxp_pkg::*;
#(
    parameter int SEW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic           op_sub,
    input  logic           is_signed,
    input  logic           avg_mode,
    input  logic [1:0]     rnd_mode,
    input  logic [SEW-1:0] opa,
    input  logic [SEW-1:0] opb,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [SEW-1:0] res,
    output logic           sat,
    input  logic           sticky_clr,
    output logic           sat_sticky
);
    localparam int WIDE = SEW + 1;

    typedef struct packed {
        logic           vld;
        logic [SEW-1:0] res;
        logic           sat;
        logic           sticky;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    logic [WIDE-1:0] wide;
    logic [SEW-1:0]  clamped;
    logic            clipped;
    logic [SEW-1:0]  halved;
    logic [SEW-1:0]  lane_res;
    logic            lane_sat;
    logic            accept;

    fxp_wide_alu #(.SEW(SEW)) u_alu (
        .opa       (opa),
        .opb       (opb),
        .op_sub    (op_sub),
        .is_signed (is_signed),
        .wide      (wide)
    );

    fxp_sat_clamp #(.SEW(SEW)) u_clamp (
        .wide      (wide),
        .op_sub    (op_sub),
        .is_signed (is_signed),
        .clamped   (clamped),
        .clipped   (clipped)
    );

    fxp_half_round #(.SEW(SEW)) u_round (
        .wide   (wide),
        .mode   (rnd_e'(rnd_mode)),
        .halved (halved)
    );

    always_comb begin
        lane_res = avg_mode ? halved : clamped;
        lane_sat = ~avg_mode & clipped;
        in_ready = ~stage_q.vld | out_ready;
        accept   = in_valid & in_ready;

        stage_d = stage_q;
        if (out_ready) begin
            stage_d.vld = 1'b0;
        end
        if (accept) begin
            stage_d.vld = 1'b1;
            stage_d.res = lane_res;
            stage_d.sat = lane_sat;
        end
        if (sticky_clr) begin
            stage_d.sticky = 1'b0;
        end
        if (accept && lane_sat) begin
            stage_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.vld;
    assign res        = stage_q.res;
    assign sat        = stage_q.sat;
    assign sat_sticky = stage_q.sticky;

endmodule

// File: rtl/fxp_addavg_chk.sv
module fxp_addavg_chk #(
    parameter int SEW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           op_sub,
    input logic           is_signed,
    input logic           avg_mode,
    input logic [1:0]     rnd_mode,
    input logic [SEW-1:0] opa,
    input logic [SEW-1:0] opb,
    input logic           out_valid,
    input logic           out_ready,
    input logic [SEW-1:0] res,
    input logic           sat,
    input logic           sticky_clr,
    input logic           sat_sticky
);
    localparam int MSB = SEW - 1;

    logic           take;
    logic [SEW:0]   u_sum;
    logic           u_borrow;
    logic [SEW-1:0] s_add;
    logic [SEW-1:0] s_sub;
    logic           s_ovf;
    logic [SEW:0]   x_a;
    logic [SEW:0]   x_b;
    logic [SEW:0]   x_full;

    always_comb begin
        take     = in_valid && in_ready;
        u_sum    = {1'b0, opa} + {1'b0, opb};
        u_borrow = opa < opb;
        s_add    = opa + opb;
        s_sub    = opa - opb;
        if (op_sub) begin
            s_ovf = (opa[MSB] != opb[MSB]) && (s_sub[MSB] != opa[MSB]);
        end else begin
            s_ovf = (opa[MSB] == opb[MSB]) && (s_add[MSB] != opa[MSB]);
        end
        x_a    = is_signed ? {opa[MSB], opa} : {1'b0, opa};
        x_b    = is_signed ? {opb[MSB], opb} : {1'b0, opb};
        x_full = op_sub ? (x_a - x_b) : (x_a + x_b);
    end

    assert_uadd_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take && !avg_mode && !is_signed && !op_sub |=>
            sat == $past(u_sum[SEW]) &&
            res == ($past(u_sum[SEW]) ? {SEW{1'b1}} : $past(u_sum[SEW-1:0])));

    assert_usub_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take && !avg_mode && !is_signed && op_sub |=>
            sat == $past(u_borrow) &&
            res == ($past(u_borrow) ? {SEW{1'b0}} : $past(s_sub)));

    assert_signed_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take && !avg_mode && is_signed |=> sat == $past(s_ovf));

    assert_trunc_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && avg_mode && rnd_mode == 2'd2 |=> res == $past(x_full[SEW:1]));

    assert_avg_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take && avg_mode |=> !sat);

    assert_take_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(res) && $stable(sat));

    assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    assert_sticky_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky && !sticky_clr |=> sat_sticky);

endmodule

bind fxp_addavg fxp_addavg_chk #(.SEW(SEW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .op_sub     (op_sub),
    .is_signed  (is_signed),
    .avg_mode   (avg_mode),
    .rnd_mode   (rnd_mode),
    .opa        (opa),
    .opb        (opb),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .res        (res),
    .sat        (sat),
    .sticky_clr (sticky_clr),
    .sat_sticky (sat_sticky)
);

// File: tb/fxp_addavg_test.sv
`timescale 1ns/1ps
module fxp_addavg_test;
    localparam int SEW = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic           in_ready;
    logic           op_sub;
    logic           is_signed;
    logic           avg_mode;
    logic [1:0]     rnd_mode;
    logic [SEW-1:0] opa;
    logic [SEW-1:0] opb;
    logic           out_valid;
    logic           out_ready;
    logic [SEW-1:0] res;
    logic           sat;
    logic           sticky_clr;
    logic           sat_sticky;

    int checks = 0;
    int errors = 0;

    logic [SEW:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    fxp_addavg #(.SEW(SEW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .op_sub     (op_sub),
        .is_signed  (is_signed),
        .avg_mode   (avg_mode),
        .rnd_mode   (rnd_mode),
        .opa        (opa),
        .opb        (opb),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .res        (res),
        .sat        (sat),
        .sticky_clr (sticky_clr),
        .sat_sticky (sat_sticky)
    );

    // expected {sat,res} from the requirements
    function automatic logic [SEW:0] model(input logic [SEW-1:0] a, input logic [SEW-1:0] b,
                                           input logic sub, input logic sgn, input logic avg,
                                           input logic [1:0] rm);
        longint av, bv, w, lo, hi, v, q;
        logic b0, b1, inc;
        av = sgn ? longint'($signed(a)) : longint'(a);
        bv = sgn ? longint'($signed(b)) : longint'(b);
        w  = sub ? av - bv : av + bv;
        if (!avg) begin
            if (sgn) begin
                hi = (longint'(1) <<< (SEW-1)) - 1;
                lo = -(longint'(1) <<< (SEW-1));
            end else begin
                hi = (longint'(1) <<< SEW) - 1;
                lo = 0;
            end
            if (w > hi) return {1'b1, hi[SEW-1:0]};
            if (w < lo) return {1'b1, lo[SEW-1:0]};
            return {1'b0, w[SEW-1:0]};
        end
        v  = w & ((longint'(1) <<< (SEW+1)) - 1);
        b0 = v[0];
        b1 = v[1];
        case (rm)
            2'd0:    inc = b0;
            2'd1:    inc = b0 & b1;
            2'd2:    inc = 1'b0;
            default: inc = b0 & ~b1;
        endcase
        q = (v >> 1) + longint'(inc);
        return {1'b0, q[SEW-1:0]};
    endfunction

    function automatic string tag_of(input logic sub, input logic sgn, input logic avg,
                                     input logic clip);
        if (avg) return sgn ? "R6 R7 R8" : "R5 R7 R8";
        if (!clip) return "R4";
        if (sgn) return "R3";
        return sub ? "R2" : "R1";
    endfunction

    task automatic check(input string req, input logic [SEW:0] act, input logic [SEW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [SEW-1:0] a, input logic [SEW-1:0] b, input logic sub,
                        input logic sgn, input logic avg, input logic [1:0] rm);
        logic [SEW:0] e;
        @(negedge clk);
        opa = a; opb = b; op_sub = sub; is_signed = sgn; avg_mode = avg; rnd_mode = rm;
        in_valid = 1'b1;
        forever begin
            #2;
            if (in_ready) break;
            @(negedge clk);
        end
        e = model(a, b, sub, sgn, avg, rm);
        exp_q.push_back(e);
        tag_q.push_back(tag_of(sub, sgn, avg, e[SEW]));
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: randomised consumer, pops expected items on each transfer
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            out_ready = ($urandom_range(3) != 0);
            #1;
            if (rst_n && out_valid) begin
                if (out_ready) begin
                    if (exp_q.size() == 0) begin
                        check("R9 unexpected output", {sat, res}, {(SEW+1){1'bx}});
                    end else begin
                        check(tag_q.pop_front(), {sat, res}, exp_q.pop_front());
                    end
                end else begin
                    check("R9 stall blocks input", {{SEW{1'b0}}, in_ready}, '0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; is_signed = 1'b0; avg_mode = 1'b0;
        rnd_mode = 2'd0; opa = '0; opb = '0; sticky_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R11 reset out_valid", {{SEW{1'b0}}, out_valid}, '0);
        check("R11 reset sat_sticky", {{SEW{1'b0}}, sat_sticky}, '0);
        check("R11 reset in_ready", {{SEW{1'b0}}, in_ready}, {{SEW{1'b0}}, 1'b1});
        rst_n = 1'b1;

        // R4: in-range saturating results, no sticky effect
        send(8'h10, 8'h20, 1'b0, 1'b0, 1'b0, 2'd0);
        send(8'h30, 8'h10, 1'b1, 1'b0, 1'b0, 2'd0);
        send(8'h05, 8'h07, 1'b1, 1'b1, 1'b0, 2'd0);
        drain();
        check("R10 no clamp keeps sticky low", {{SEW{1'b0}}, sat_sticky}, '0);

        // R1, R2, R3 clamps
        send(8'hF0, 8'h20, 1'b0, 1'b0, 1'b0, 2'd0);
        send(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0);
        send(8'h10, 8'h20, 1'b1, 1'b0, 1'b0, 2'd0);
        send(8'h7F, 8'h01, 1'b0, 1'b1, 1'b0, 2'd0);
        send(8'h80, 8'hFF, 1'b0, 1'b1, 1'b0, 2'd0);
        send(8'h80, 8'h01, 1'b1, 1'b1, 1'b0, 2'd0);
        send(8'h7F, 8'hFF, 1'b1, 1'b1, 1'b0, 2'd0);
        drain();
        check("R10 clamp sets sticky", {{SEW{1'b0}}, sat_sticky}, {{SEW{1'b0}}, 1'b1});
        @(negedge clk); sticky_clr = 1'b1;
        @(negedge clk); sticky_clr = 1'b0;
        #1;
        check("R10 clear drops sticky", {{SEW{1'b0}}, sat_sticky}, '0);

        // R5, R6, R7: every rounding mode on odd/even tie patterns
        for (int m = 0; m < 4; m++) begin
            send(8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 2'(m));
            send(8'h01, 8'h04, 1'b0, 1'b0, 1'b1, 2'(m));
            send(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 2'(m));
            send(8'h00, 8'h01, 1'b1, 1'b0, 1'b1, 2'(m));
            send(8'h7F, 8'h80, 1'b1, 1'b1, 1'b1, 2'(m));
            send(8'hFF, 8'hFE, 1'b0, 1'b1, 1'b1, 2'(m));
            send(8'h80, 8'h80, 1'b0, 1'b1, 1'b1, 2'(m));
        end
        drain();
        check("R8 averaging leaves sticky low", {{SEW{1'b0}}, sat_sticky}, '0);

        for (int i = 0; i < 3000; i++) begin
            send(SEW'($urandom), SEW'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 2'($urandom));
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule